// File: doc/BRIEF.md
# Programmable Hub Slot Scheduler

This block decides which of sixteen cores may use a shared memory hub on each access slot. Instead of a fixed rotation, the order comes from a schedule table of thirty-two 4-bit core numbers. A scan pointer walks the table one position per slot strobe. The core named at the current position is granted the slot, but only if that core is requesting.

Software sets the schedule in two parts. A single 128-bit write replaces the whole table at once, so a half-written schedule is never used. A 5-bit limit sets the last table position before the pointer returns to zero, so the active schedule can be shorter than the table. Both updates are held back until the pointer wraps.

Because a core number may appear any number of times, some cores can be given a higher slot rate than others. A core that is missing from the active part of the table gets no hub slots at all. After reset the schedule is a plain sixteen-slot rotation, so no setup is needed.

Top module: `hub_slot_sched`

## Requirements
- R1: After reset, table position k holds core k mod 16 and the limit is 15. Each of the 16 cores is granted once per 16 strobes, in ascending order.
- R2: Each strobe on `advance` produces exactly one scheduling decision, visible on the cycle after the strobe. A cycle with no strobe leaves `grant` at zero and `grant_vld` low one cycle later. At most one `grant` bit is ever high.
- R3: A decision grants the core whose number is stored at the current scan position, and only if that core's `req` bit was high during the strobe. A slot whose core is not requesting is left idle and is not given to any other core. `grant_id` always shows the scheduled core number.
- R4: The scan pointer runs from position 0 up to the active limit, then returns to 0. A limit of 27 therefore repeats every 28 strobes.
- R5: Table writes and limit writes are held pending. They take effect only after a strobe at the last position of the scan (a wrap). A write made in the same cycle as a wrap waits for the next wrap. If several writes arrive before a wrap, the latest one is used.
- R6: A limit of 0 schedules position 0 on every strobe. A limit of 31 uses all 32 positions.
- R7: `tbl_rd` returns the active table, with position k in bits [4k+3:4k]. `rld_rd` returns the active limit.
- R8: A core number may appear at any position and any number of times. A core that is absent from the active positions is never granted.
- R9: Whenever `grant_vld` is high, `grant` has exactly the single bit at index `grant_id` set. Both outputs are registered and change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr | input | 1 | Write strobe for a new schedule table |
| tbl_wdata | input | 128 | New table; position k in bits [4k+3:4k] |
| rld_wr | input | 1 | Write strobe for a new scan limit |
| rld_wdata | input | 5 | New scan limit (last position before wrap) |
| req | input | 16 | Per-core request bits |
| advance | input | 1 | Slot strobe; one scheduling decision per high cycle |
| grant | output | 16 | One-hot grant, registered |
| grant_id | output | 4 | Core number scheduled by the last strobe |
| grant_vld | output | 1 | High when the last strobe granted its core |
| tbl_rd | output | 128 | Active table readback |
| rld_rd | output | 5 | Active scan limit readback |

## Verification
The hardest case to reach is a configuration write that lands in exactly the cycle of a wrap. Here the old pending value commits while the new value must wait for a full further scan.

The bench tracks the scan position in its own model. It walks the pointer forward until the model reports the last position, then issues a table write and a limit write in that same strobe cycle. The following scans are then checked against the previous schedule before the switch is seen.

Mid-scan writes, a shortened 28-slot scan, and the one-position and full-table limits are driven the same way. Every strobe is compared with the model.

// File: rtl/hub_sched_pkg.sv
package hub_sched_pkg;

   // Default geometry of the scheduler
   localparam int unsigned CORES_DEF   = 16;
   localparam int unsigned ENTRIES_DEF = 32;

   // Core number placed at table position k after reset: plain rotation
   function automatic int unsigned rotation_core(input int unsigned k,
                                                 input int unsigned cores);
      return k % cores;
   endfunction

endpackage

// File: rtl/hub_sched_cfg.sv
module hub_sched_cfg
   import hub_sched_pkg::*;
#(
   parameter int unsigned N_CORES   = CORES_DEF,
   parameter int unsigned N_ENTRIES = ENTRIES_DEF,
   localparam int unsigned ID_W  = $clog2(N_CORES),
   localparam int unsigned IDX_W = $clog2(N_ENTRIES),
   localparam int unsigned TBL_W = N_ENTRIES * ID_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tbl_wr,
   input  logic [TBL_W-1:0] tbl_wdata,
   input  logic             rld_wr,
   input  logic [IDX_W-1:0] rld_wdata,
   input  logic             commit,
   output logic [TBL_W-1:0] act_tbl,
   output logic [IDX_W-1:0] act_rld
);

   localparam logic [IDX_W-1:0] RLD_RESET = IDX_W'(N_CORES - 1);

   logic [TBL_W-1:0] rot_tbl;
   logic [TBL_W-1:0] pend_tbl;
   logic [IDX_W-1:0] pend_rld;
   logic             pend_tbl_v;
   logic             pend_rld_v;

   // Reset image of the table, built position by position
   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_rot
      assign rot_tbl[g*ID_W +: ID_W] = ID_W'(rotation_core(g, N_CORES));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_tbl    <= rot_tbl;
         act_rld    <= RLD_RESET;
         pend_tbl   <= '0;
         pend_rld   <= '0;
         pend_tbl_v <= 1'b0;
         pend_rld_v <= 1'b0;
      end else begin
         if (commit) begin
            if (pend_tbl_v) act_tbl <= pend_tbl;
            if (pend_rld_v) act_rld <= pend_rld;
            pend_tbl_v <= 1'b0;
            pend_rld_v <= 1'b0;
         end
         // A write in the commit cycle lands in the pending slot for the next wrap
         if (tbl_wr) begin
            pend_tbl   <= tbl_wdata;
            pend_tbl_v <= 1'b1;
         end
         if (rld_wr) begin
            pend_rld   <= rld_wdata;
            pend_rld_v <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hub_sched_scan.sv
module hub_sched_scan
   import hub_sched_pkg::*;
#(
   parameter int unsigned N_ENTRIES = ENTRIES_DEF,
   localparam int unsigned IDX_W = $clog2(N_ENTRIES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [IDX_W-1:0] act_rld,
   output logic [IDX_W-1:0] ptr,
   output logic             wrap
);

   logic [IDX_W-1:0] last_pos;

   // Clamp the limit only when the index field can name missing positions
   if ((1 << IDX_W) == N_ENTRIES) begin : g_pow2
      assign last_pos = act_rld;
   end else begin : g_clamp
      localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);
      assign last_pos = (act_rld > TOP) ? TOP : act_rld;
   end

   assign wrap = advance && (ptr >= last_pos);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (wrap)
         ptr <= '0;
      else if (advance)
         ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/hub_sched_grant.sv
module hub_sched_grant
   import hub_sched_pkg::*;
#(
   parameter int unsigned N_CORES   = CORES_DEF,
   parameter int unsigned N_ENTRIES = ENTRIES_DEF,
   localparam int unsigned ID_W  = $clog2(N_CORES),
   localparam int unsigned IDX_W = $clog2(N_ENTRIES),
   localparam int unsigned TBL_W = N_ENTRIES * ID_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   input  logic [N_CORES-1:0] req,
   input  logic [TBL_W-1:0]   act_tbl,
   input  logic [IDX_W-1:0]   ptr,
   output logic [N_CORES-1:0] grant,
   output logic [ID_W-1:0]    grant_id,
   output logic               grant_vld
);

   logic [ID_W-1:0]    sel_id;
   logic [N_CORES-1:0] sel_hot;
   logic               sel_take;

   assign sel_id = act_tbl[ptr*ID_W +: ID_W];

   // Decoder of the scheduled core
   for (genvar c = 0; c < N_CORES; c++) begin : g_dec
      assign sel_hot[c] = (sel_id == ID_W'(c));
   end

   assign sel_take = advance && |(sel_hot & req);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant     <= '0;
         grant_id  <= '0;
         grant_vld <= 1'b0;
      end else begin
         grant     <= sel_take ? sel_hot : '0;
         grant_vld <= sel_take;
         if (advance) grant_id <= sel_id;
      end
   end

endmodule

// File: rtl/hub_slot_sched.sv
module hub_slot_sched
   import hub_sched_pkg::*;
#(
   parameter int unsigned N_CORES   = CORES_DEF,
   parameter int unsigned N_ENTRIES = ENTRIES_DEF,
   localparam int unsigned ID_W  = $clog2(N_CORES),
   localparam int unsigned IDX_W = $clog2(N_ENTRIES),
   localparam int unsigned TBL_W = N_ENTRIES * ID_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_wr,
   input  logic [TBL_W-1:0]   tbl_wdata,
   input  logic               rld_wr,
   input  logic [IDX_W-1:0]   rld_wdata,
   input  logic [N_CORES-1:0] req,
   input  logic               advance,
   output logic [N_CORES-1:0] grant,
   output logic [ID_W-1:0]    grant_id,
   output logic               grant_vld,
   output logic [TBL_W-1:0]   tbl_rd,
   output logic [IDX_W-1:0]   rld_rd
);

   // Elaboration-time checks of the geometry
   if (N_CORES < 2 || (1 << ID_W) != N_CORES) begin : g_bad_cores
      $error("hub_slot_sched: N_CORES must be a power of two, at least 2");
   end
   if (N_ENTRIES < N_CORES) begin : g_bad_entries
      $error("hub_slot_sched: N_ENTRIES must cover every core once");
   end

   logic [TBL_W-1:0] act_tbl;
   logic [IDX_W-1:0] act_rld;
   logic [IDX_W-1:0] scan_ptr;
   logic             scan_wrap;

   hub_sched_cfg #(.N_CORES(N_CORES), .N_ENTRIES(N_ENTRIES)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .tbl_wr    (tbl_wr),
      .tbl_wdata (tbl_wdata),
      .rld_wr    (rld_wr),
      .rld_wdata (rld_wdata),
      .commit    (scan_wrap),
      .act_tbl   (act_tbl),
      .act_rld   (act_rld)
   );

   hub_sched_scan #(.N_ENTRIES(N_ENTRIES)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .act_rld (act_rld),
      .ptr     (scan_ptr),
      .wrap    (scan_wrap)
   );

   hub_sched_grant #(.N_CORES(N_CORES), .N_ENTRIES(N_ENTRIES)) u_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .req       (req),
      .act_tbl   (act_tbl),
      .ptr       (scan_ptr),
      .grant     (grant),
      .grant_id  (grant_id),
      .grant_vld (grant_vld)
   );

   assign tbl_rd = act_tbl;
   assign rld_rd = act_rld;

endmodule

// File: rtl/hub_slot_sched_chk.sv
module hub_slot_sched_chk #(
   parameter int unsigned N_CORES   = 16,
   parameter int unsigned N_ENTRIES = 32,
   localparam int unsigned ID_W  = $clog2(N_CORES),
   localparam int unsigned IDX_W = $clog2(N_ENTRIES),
   localparam int unsigned TBL_W = N_ENTRIES * ID_W
)(
   input logic               clk,
   input logic               rst_n,
   input logic               advance,
   input logic [N_CORES-1:0] req,
   input logic [N_CORES-1:0] grant,
   input logic [ID_W-1:0]    grant_id,
   input logic               grant_vld,
   input logic [TBL_W-1:0]   tbl_rd,
   input logic [IDX_W-1:0]   rld_rd,
   input logic [IDX_W-1:0]   scan_ptr,
   input logic               scan_wrap
);

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_idle_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> (grant == '0) && !grant_vld);

   assert_grant_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> ((grant & $past(req)) == grant));

   assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scan_ptr <= rld_rd);

   assert_cfg_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_wrap |=> $stable(tbl_rd) && $stable(rld_rd));

   assert_id_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> (grant == (N_CORES'(1) << grant_id)));

endmodule

bind hub_slot_sched hub_slot_sched_chk #(.N_CORES(N_CORES), .N_ENTRIES(N_ENTRIES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .advance   (advance),
   .req       (req),
   .grant     (grant),
   .grant_id  (grant_id),
   .grant_vld (grant_vld),
   .tbl_rd    (tbl_rd),
   .rld_rd    (rld_rd),
   .scan_ptr  (scan_ptr),
   .scan_wrap (scan_wrap)
);

// File: tb/hub_slot_sched_test.sv
`timescale 1ns/1ps
module hub_slot_sched_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tbl_wr = 1'b0;
   logic [127:0] tbl_wdata = '0;
   logic         rld_wr = 1'b0;
   logic [4:0]   rld_wdata = '0;
   logic [15:0]  req = '0;
   logic         advance = 1'b0;
   logic [15:0]  grant;
   logic [3:0]   grant_id;
   logic         grant_vld;
   logic [127:0] tbl_rd;
   logic [4:0]   rld_rd;

   always #4 clk = ~clk;

   hub_slot_sched uut (
      .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
      .rld_wr(rld_wr), .rld_wdata(rld_wdata), .req(req), .advance(advance),
      .grant(grant), .grant_id(grant_id), .grant_vld(grant_vld),
      .tbl_rd(tbl_rd), .rld_rd(rld_rd)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference state
   logic [127:0] m_act, m_pend;
   logic [4:0]   m_rld, m_prld;
   bit           m_pt, m_pr;
   int           m_ptr;
   int           core9_grants;

   function automatic logic [127:0] rot_table();
      logic [127:0] t;
      for (int k = 0; k < 32; k++) t[k*4 +: 4] = 4'(k % 16);
      return t;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // One clock of stimulus, starting and ending at a falling edge
   task automatic step(input bit adv, input logic [15:0] rq, input bit twr,
                       input logic [127:0] td, input bit rwr, input logic [4:0] rd,
                       input string tag);
      logic [3:0]  e_id;
      bit          e_vld;
      bit          wr;
      advance = adv; req = rq; tbl_wr = twr; tbl_wdata = td;
      rld_wr = rwr; rld_wdata = rd;
      e_id  = m_act[m_ptr*4 +: 4];
      e_vld = adv && rq[e_id];
      wr    = adv && (m_ptr >= int'(m_rld));
      if (adv) m_ptr = wr ? 0 : m_ptr + 1;
      if (wr) begin
         if (m_pt) m_act = m_pend;
         if (m_pr) m_rld = m_prld;
         m_pt = 0; m_pr = 0;
      end
      if (twr) begin m_pend = td; m_pt = 1; end
      if (rwr) begin m_prld = rd; m_pr = 1; end
      @(posedge clk);
      @(negedge clk);
      chk(grant_vld == e_vld, tag, 128'(grant_vld), 128'(e_vld));
      chk(grant == (e_vld ? (16'd1 << e_id) : 16'd0), "R9", 128'(grant),
          128'(e_vld ? (16'd1 << e_id) : 16'd0));
      if (adv) chk(grant_id == e_id, tag, 128'(grant_id), 128'(e_id));
      chk(tbl_rd == m_act && rld_rd == m_rld, "R7", tbl_rd, m_act);
      if (grant[9]) core9_grants++;
      advance = 0; tbl_wr = 0; rld_wr = 0;
   endtask

   task automatic run(input int n, input logic [15:0] rq, input string tag);
      for (int i = 0; i < n; i++) step(1'b1, rq, 1'b0, '0, 1'b0, '0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      logic [127:0] t;
      m_act = rot_table(); m_rld = 5'd15; m_pend = '0; m_prld = '0;
      m_pt = 0; m_pr = 0; m_ptr = 0; core9_grants = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk(grant == 0 && !grant_vld, "R1", 128'(grant), 128'd0);
      chk(tbl_rd == rot_table(), "R1", tbl_rd, rot_table());
      chk(rld_rd == 5'd15, "R1", 128'(rld_rd), 128'd15);

      // R1: default rotation, every core requesting
      run(32, 16'hFFFF, "R1");
      // R2: no strobe, no grant
      for (int i = 0; i < 3; i++) step(1'b0, 16'hFFFF, 1'b0, '0, 1'b0, '0, "R2");
      // R3: only odd cores request; idle slots stay idle
      run(16, 16'hAAAA, "R3");
      run(16, 16'h0001, "R3");

      // R5: mid-scan table write, cores 0 and 1 take half the slots
      run(5, 16'hFFFF, "R5");
      for (int k = 0; k < 32; k++)
         t[k*4 +: 4] = (k % 2 == 0) ? 4'((k >> 1) & 1) : 4'(2 + ((k >> 1) % 14));
      step(1'b1, 16'hFFFF, 1'b1, t, 1'b0, '0, "R5");
      run(40, 16'hFFFF, "R5");
      // R4: limit 27 gives a 28-slot scan
      run(3, 16'hFFFF, "R4");
      step(1'b1, 16'hFFFF, 1'b0, '0, 1'b1, 5'd27, "R4");
      run(90, 16'hFFFF, "R4");

      // R5: write in the exact wrap cycle waits for the next wrap
      while (m_ptr != int'(m_rld)) step(1'b1, 16'hFFFF, 1'b0, '0, 1'b0, '0, "R5");
      for (int k = 0; k < 32; k++) t[k*4 +: 4] = 4'(15 - (k % 16));
      step(1'b1, 16'hFFFF, 1'b1, t, 1'b1, 5'd20, "R5");
      run(60, 16'hFFFF, "R5");

      // R8: table without core 9, duplicates of others
      for (int k = 0; k < 32; k++) t[k*4 +: 4] = 4'(k % 7);
      step(1'b1, 16'hFFFF, 1'b1, t, 1'b1, 5'd31, "R8");
      run(30, 16'hFFFF, "R8");
      core9_grants = 0;
      run(96, 16'hFFFF, "R8");
      chk(core9_grants == 0, "R8", 128'(core9_grants), 128'd0);

      // R6: limit 0 then limit 31
      step(1'b1, 16'hFFFF, 1'b1, rot_table(), 1'b1, 5'd0, "R6");
      run(40, 16'hFFFF, "R6");
      chk(m_ptr == 0 && rld_rd == 5'd0, "R6", 128'(rld_rd), 128'd0);
      step(1'b1, 16'hFFFF, 1'b0, '0, 1'b1, 5'd31, "R6");
      run(70, 16'h5555, "R6");

      done = 1'b1;
      report();
   end

endmodule